// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timing Generator

This block times a single access on an asynchronous parallel display bus. On a start request it runs a tick counter from zero and drives the chip-select, write-enable and read-enable lines. Each line has its own programmable first and last tick. The register-select line carries the command/data flag for the whole access. A cycle length, chosen by access direction, ends the access with a one-clock done pulse. For reads, a separate access-time tick picks the clock on which the incoming bus data is captured. A granularity input stretches every tick to two base clocks. Each of the four bus lines has its own polarity bit.

Timing fields that break the ordering rules are repaired in hardware before use. An off tick at or below its on tick becomes on+1. Chip-select is stretched to cover both data strobes. The access time is pushed past the read-enable on tick. The cycle length is raised so that the whole access fits. All timing fields, the granularity bit and the direction and command flags are latched when an access is accepted. The polarity bits act live.

The controller is a three-state machine. ST_IDLE waits for a start request and takes it (transition "accept"). ST_RUN counts ticks. When the last clock of tick L arrives, where L is the effective cycle length, it moves to ST_DONE (transition "finish"). ST_DONE lasts one clock, raises done, and returns unconditionally to ST_IDLE (transition "release").

Top module: `strobe_gen`

## Requirements
- R1: After reset every bus line sits at its inactive level, done is 0 and the captured read value is 0.
- R2: Tick 0 is the first clock after the clock edge that accepts a start. A strobe is logically active for ticks t with on <= t < off. Outside ST_RUN no strobe is active.
- R3: A write access (rd_i=0) pulses only write-enable and a read access (rd_i=1) pulses only read-enable. Chip-select is used by both.
- R4: For write-enable and read-enable, an off value less than or equal to on is replaced by on+1. The same applies to chip-select before R5.
- R5: The chip-select off tick is raised to the larger of itself, the effective write-enable off and the effective read-enable off.
- R6: The effective cycle length L is max(wr_cyc_i, effective cs off) for writes and max(rd_cyc_i, effective cs off, effective access time) for reads. done_o is high for exactly one clock, right after the last clock of tick L.
- R7: With gran_i=1 each tick lasts two base clocks instead of one.
- R8: The polarity bits are pol_i[0] for chip-select, pol_i[1] for write-enable, pol_i[2] for read-enable and pol_i[3] for register-select. 1 makes the line active-high and 0 makes it active-low.
- R9: During ST_RUN the register-select line is logically active exactly when the latched cmd_i was 1. Otherwise it is logically inactive.
- R10: A start request is ignored while an access is in ST_RUN or ST_DONE.
- R11: On a read, rd_data_i is captured into rd_q_o at the first clock of the effective access tick. The effective access tick is acc_i, or re_on_i+1 when acc_i <= re_on_i. rd_q_o holds its value through write accesses.
- R12: Timing fields, gran_i, rd_i and cmd_i are sampled at acceptance. Changing them during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Access request, taken in ST_IDLE |
| rd_i | input | 1 | 1 = read access, 0 = write access |
| cmd_i | input | 1 | 1 = command access (drives register-select) |
| gran_i | input | 1 | 1 = two base clocks per tick |
| pol_i | input | 4 | Polarity: [0] cs, [1] we, [2] re, [3] register-select |
| cs_on_i | input | 4 | Chip-select on tick |
| cs_off_i | input | 6 | Chip-select off tick |
| we_on_i | input | 4 | Write-enable on tick |
| we_off_i | input | 6 | Write-enable off tick |
| re_on_i | input | 4 | Read-enable on tick |
| re_off_i | input | 6 | Read-enable off tick |
| wr_cyc_i | input | 6 | Write cycle length in ticks |
| rd_cyc_i | input | 6 | Read cycle length in ticks |
| acc_i | input | 6 | Read access (capture) tick |
| rd_data_i | input | DW | Bus read data |
| cs_o | output | 1 | Chip-select line |
| we_o | output | 1 | Write-enable line |
| re_o | output | 1 | Read-enable line |
| a0_o | output | 1 | Register-select (command/data) line |
| done_o | output | 1 | One-clock end-of-access pulse |
| rd_q_o | output | DW | Last captured read data |

## Verification
The bench predicts a trace that starts one clock after the accepting edge. Clock k of that trace carries tick k>>gran. done_o is due in clock (L+1)*(gran+1), followed by one idle clock. The expected line levels for every clock are queued when the start is dropped, and a monitor compares one entry on every falling edge, so each prediction meets exactly the clock it names. A bench stamp that changes once per clock feeds rd_data_i. The capture is due on the stamp of clock acc*(gran+1), and it is checked in the done and idle clocks.

// File: rtl/strobe_gen_pkg.sv
package strobe_gen_pkg;
    localparam int ON_W  = 4;
    localparam int OFF_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [OFF_W-1:0] cs_on;
        logic [OFF_W-1:0] cs_off;
        logic [OFF_W-1:0] we_on;
        logic [OFF_W-1:0] we_off;
        logic [OFF_W-1:0] re_on;
        logic [OFF_W-1:0] re_off;
        logic [OFF_W-1:0] wr_len;
        logic [OFF_W-1:0] rd_len;
        logic [OFF_W-1:0] acc;
    } tset_t;
endpackage

// File: rtl/strobe_clamp.sv
module strobe_clamp
    import strobe_gen_pkg::*;
(
    input  logic [ON_W-1:0]  cs_on_i,
    input  logic [OFF_W-1:0] cs_off_i,
    input  logic [ON_W-1:0]  we_on_i,
    input  logic [OFF_W-1:0] we_off_i,
    input  logic [ON_W-1:0]  re_on_i,
    input  logic [OFF_W-1:0] re_off_i,
    input  logic [OFF_W-1:0] wr_cyc_i,
    input  logic [OFF_W-1:0] rd_cyc_i,
    input  logic [OFF_W-1:0] acc_i,
    output tset_t            cfg_o
);
    localparam int PAD = OFF_W - ON_W;

    function automatic logic [OFF_W-1:0] past_on(input logic [OFF_W-1:0] on,
                                                 input logic [OFF_W-1:0] off);
        return (off <= on) ? on + 1'b1 : off;
    endfunction

    function automatic logic [OFF_W-1:0] mx(input logic [OFF_W-1:0] a,
                                            input logic [OFF_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    logic [OFF_W-1:0] cs_on_w, we_on_w, re_on_w;
    logic [OFF_W-1:0] we_off_e, re_off_e, cs_off_e, acc_e;

    always_comb begin
        cs_on_w  = {{PAD{1'b0}}, cs_on_i};
        we_on_w  = {{PAD{1'b0}}, we_on_i};
        re_on_w  = {{PAD{1'b0}}, re_on_i};
        we_off_e = past_on(we_on_w, we_off_i);
        re_off_e = past_on(re_on_w, re_off_i);
        cs_off_e = mx(past_on(cs_on_w, cs_off_i), mx(we_off_e, re_off_e));
        acc_e    = past_on(re_on_w, acc_i);

        cfg_o.cs_on  = cs_on_w;
        cfg_o.cs_off = cs_off_e;
        cfg_o.we_on  = we_on_w;
        cfg_o.we_off = we_off_e;
        cfg_o.re_on  = re_on_w;
        cfg_o.re_off = re_off_e;
        cfg_o.acc    = acc_e;
        cfg_o.wr_len = mx(wr_cyc_i, cs_off_e);
        cfg_o.rd_len = mx(mx(rd_cyc_i, cs_off_e), acc_e);
    end
endmodule

// File: rtl/strobe_prescale.sv
module strobe_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic gran_i,
    output logic first_o,
    output logic last_o
);
    logic half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            half <= 1'b0;
        else if (clear_i)
            half <= 1'b0;
        else if (run_i && gran_i)
            half <= ~half;
        else
            half <= 1'b0;
    end

    assign first_o = !gran_i || !half;
    assign last_o  = !gran_i || half;
endmodule

// File: rtl/strobe_window.sv
module strobe_window #(
    parameter int CW = 6
) (
    input  logic          run_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] on_i,
    input  logic [CW-1:0] off_i,
    input  logic          hi_i,
    output logic          act_o,
    output logic          pin_o
);
    assign act_o = run_i && (cnt_i >= on_i) && (cnt_i < off_i);
    assign pin_o = hi_i ? act_o : ~act_o;
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
    import strobe_gen_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rd_i,
    input  logic             cmd_i,
    input  logic             gran_i,
    input  logic [3:0]       pol_i,
    input  logic [ON_W-1:0]  cs_on_i,
    input  logic [OFF_W-1:0] cs_off_i,
    input  logic [ON_W-1:0]  we_on_i,
    input  logic [OFF_W-1:0] we_off_i,
    input  logic [ON_W-1:0]  re_on_i,
    input  logic [OFF_W-1:0] re_off_i,
    input  logic [OFF_W-1:0] wr_cyc_i,
    input  logic [OFF_W-1:0] rd_cyc_i,
    input  logic [OFF_W-1:0] acc_i,
    input  logic [DW-1:0]    rd_data_i,
    output logic             cs_o,
    output logic             we_o,
    output logic             re_o,
    output logic             a0_o,
    output logic             done_o,
    output logic [DW-1:0]    rd_q_o
);
    localparam int NSTB = 3;

    seq_state_e       state, nxt;
    tset_t            cfg_c, cfg_q;
    logic [OFF_W-1:0] cnt, len;
    logic             rd_q, cmd_q, gran_q;
    logic [DW-1:0]    cap_q;
    logic             accept, tick_first, tick_last, last_tick;

    strobe_clamp u_clamp (
        .cs_on_i (cs_on_i),  .cs_off_i(cs_off_i),
        .we_on_i (we_on_i),  .we_off_i(we_off_i),
        .re_on_i (re_on_i),  .re_off_i(re_off_i),
        .wr_cyc_i(wr_cyc_i), .rd_cyc_i(rd_cyc_i),
        .acc_i   (acc_i),    .cfg_o   (cfg_c)
    );

    assign accept    = (state == ST_IDLE) && start_i;
    assign len       = rd_q ? cfg_q.rd_len : cfg_q.wr_len;
    assign last_tick = tick_last && (cnt == len);

    strobe_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(accept),
        .run_i  (state == ST_RUN),
        .gran_i (gran_q),
        .first_o(tick_first),
        .last_o (tick_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept)    nxt = ST_RUN;   // accept
            ST_RUN:  if (last_tick) nxt = ST_DONE;  // finish
            ST_DONE:                nxt = ST_IDLE;  // release
            default:                nxt = ST_IDLE;
        endcase
    end

    // access context, tick counter and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            rd_q   <= 1'b0;
            cmd_q  <= 1'b0;
            gran_q <= 1'b0;
            cnt    <= '0;
            cap_q  <= '0;
        end else begin
            if (accept) begin
                cfg_q  <= cfg_c;
                rd_q   <= rd_i;
                cmd_q  <= cmd_i;
                gran_q <= gran_i;
                cnt    <= '0;
            end else if (state == ST_RUN && tick_last && !last_tick) begin
                cnt <= cnt + 1'b1;
            end
            if (state == ST_RUN && rd_q && tick_first && cnt == cfg_q.acc)
                cap_q <= rd_data_i;
        end
    end

    // outputs: index 0 = cs, 1 = we, 2 = re
    logic [NSTB-1:0][OFF_W-1:0] on_v, off_v;
    logic [NSTB-1:0]            gate_v, hi_v, act_v, pin_v;

    assign on_v   = {cfg_q.re_on,  cfg_q.we_on,  cfg_q.cs_on};
    assign off_v  = {cfg_q.re_off, cfg_q.we_off, cfg_q.cs_off};
    assign gate_v = {rd_q, !rd_q, 1'b1};
    assign hi_v   = pol_i[2:0];

    for (genvar gi = 0; gi < NSTB; gi++) begin : g_stb
        strobe_window #(.CW(OFF_W)) u_win (
            .run_i(state == ST_RUN && gate_v[gi]),
            .cnt_i(cnt),
            .on_i (on_v[gi]),
            .off_i(off_v[gi]),
            .hi_i (hi_v[gi]),
            .act_o(act_v[gi]),
            .pin_o(pin_v[gi])
        );
    end

    logic a0_act;
    assign a0_act = (state == ST_RUN) && cmd_q;

    always_comb begin
        cs_o   = pin_v[0];
        we_o   = pin_v[1];
        re_o   = pin_v[2];
        a0_o   = pol_i[3] ? a0_act : ~a0_act;
        done_o = (state == ST_DONE);
        rd_q_o = cap_q;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_RUN |-> act_v == '0);  // R2
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_v[1] && act_v[2]));  // R3
    AST_OFF_AFTER_ON: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RUN |-> (cfg_q.we_off > cfg_q.we_on) && (cfg_q.re_off > cfg_q.re_on)
                            && (cfg_q.cs_off > cfg_q.cs_on));  // R4
    AST_CS_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RUN |-> (cfg_q.cs_off >= cfg_q.we_off) && (cfg_q.cs_off >= cfg_q.re_off));  // R5
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RUN |-> cnt <= len);  // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R6
    AST_SLOW_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && gran_q && !tick_last) |=> cnt == $past(cnt));  // R7
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && start_i && !last_tick) |=> state == ST_RUN);  // R10
endmodule

// File: tb/sim_strobe_gen.sv
module sim_strobe_gen;
    localparam int DW = 8;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       start_b = 1'b0, rd_b = 1'b0, cmd_b = 1'b0, gran_b = 1'b0;
    logic [3:0] pol_b = 4'b0000;
    logic [3:0] cs_on_b = '0, we_on_b = '0, re_on_b = '0;
    logic [5:0] cs_off_b = '0, we_off_b = '0, re_off_b = '0;
    logic [5:0] wcyc_b = '0, rcyc_b = '0, acc_b = '0;
    logic [7:0] stamp = '0;
    logic       cs_w, we_w, re_w, a0_w, dn_w;
    logic [7:0] rdq_w;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_cap = '0;

    typedef struct {
        logic cs, we, re, a0, dn;
        logic chk;
        logic [7:0] rdv;
        string tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;  // 250 MHz

    strobe_gen #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_b), .rd_i(rd_b), .cmd_i(cmd_b),
        .gran_i(gran_b), .pol_i(pol_b),
        .cs_on_i(cs_on_b), .cs_off_i(cs_off_b), .we_on_i(we_on_b), .we_off_i(we_off_b),
        .re_on_i(re_on_b), .re_off_i(re_off_b), .wr_cyc_i(wcyc_b), .rd_cyc_i(rcyc_b),
        .acc_i(acc_b), .rd_data_i(stamp),
        .cs_o(cs_w), .we_o(we_w), .re_o(re_w), .a0_o(a0_w), .done_o(dn_w), .rd_q_o(rdq_w)
    );

    // read data source: changes once per clock, 3 ns after the rising edge
    initial forever begin
        @(posedge clk);
        #3;
        stamp = stamp + 8'd1;
    end

    // monitor: one expected entry per falling edge
    initial forever begin
        @(negedge clk);
        if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (cs_w !== e.cs || we_w !== e.we || re_w !== e.re || a0_w !== e.a0 ||
                dn_w !== e.dn || (e.chk && rdq_w !== e.rdv)) begin
                n_fail++;
                $display("FAIL %s: got cs%b we%b re%b a0%b dn%b rdq%02h expected cs%b we%b re%b a0%b dn%b rdq%02h",
                         e.tag, cs_w, we_w, re_w, a0_w, dn_w, rdq_w,
                         e.cs, e.we, e.re, e.a0, e.dn, e.rdv);
            end
        end
    end

    function automatic int fix(input int on, input int off);
        return (off <= on) ? on + 1 : off;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic set_cfg(input int cson, csoff, weon, weoff, reon, reoff,
                           wcyc, rcyc, acc, input bit gran, input logic [3:0] pol);
        cs_on_b = 4'(cson); cs_off_b = 6'(csoff); we_on_b = 4'(weon); we_off_b = 6'(weoff);
        re_on_b = 4'(reon); re_off_b = 6'(reoff); wcyc_b = 6'(wcyc); rcyc_b = 6'(rcyc);
        acc_b = 6'(acc); gran_b = gran; pol_b = pol;
    endtask

    // mode 0 plain, 1 start pulse mid-access (R10), 2 inputs changed mid-access (R12)
    task automatic run_access(input string tag, input bit rd, input bit cmd, input int mode);
        int weoff_e, reoff_e, csoff_e, acc_e, len, g, n;
        logic [3:0] pol;
        logic [7:0] s0;
        weoff_e = fix(we_on_b, we_off_b);
        reoff_e = fix(re_on_b, re_off_b);
        csoff_e = mx(fix(cs_on_b, cs_off_b), mx(weoff_e, reoff_e));
        acc_e   = fix(re_on_b, acc_b);
        len     = rd ? mx(mx(rcyc_b, csoff_e), acc_e) : mx(wcyc_b, csoff_e);
        g       = gran_b ? 1 : 0;
        n       = (len + 1) * (g + 1);
        pol     = pol_b;
        rd_b = rd; cmd_b = cmd; start_b = 1'b1;
        @(posedge clk); #1;
        start_b = 1'b0;
        s0 = stamp;
        if (rd) exp_cap = s0 + 8'(acc_e * (g + 1) + 1);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            int t;
            logic ca, wa, ra;
            t  = i >> g;
            ca = (t >= cs_on_b) && (t < csoff_e);
            wa = !rd && (t >= we_on_b) && (t < weoff_e);
            ra = rd && (t >= re_on_b) && (t < reoff_e);
            e.cs = pol[0] ? ca : !ca;
            e.we = pol[1] ? wa : !wa;
            e.re = pol[2] ? ra : !ra;
            e.a0 = pol[3] ? cmd : !cmd;
            e.dn = 1'b0; e.chk = 1'b0; e.rdv = '0; e.tag = tag;
            q.push_back(e);
        end
        for (int k = 0; k < 2; k++) begin
            exp_t e;
            e.cs = !pol[0]; e.we = !pol[1]; e.re = !pol[2]; e.a0 = !pol[3];
            e.dn = (k == 0); e.chk = 1'b1; e.rdv = exp_cap;
            e.tag = (k == 0) ? {tag, " R6 done"} : {tag, " R6 single pulse"};
            q.push_back(e);
        end
        if (mode == 1) begin
            repeat (3) @(posedge clk);
            #1; start_b = 1'b1; rd_b = !rd; cmd_b = !cmd;
            @(posedge clk); #1; start_b = 1'b0;
        end else if (mode == 2) begin
            repeat (2) @(posedge clk);
            #1;
            set_cfg($urandom_range(15), $urandom_range(63), $urandom_range(15), $urandom_range(63),
                    $urandom_range(15), $urandom_range(63), $urandom_range(63), $urandom_range(63),
                    $urandom_range(63), !gran_b, pol);
            rd_b = !rd; cmd_b = !cmd;
        end
        while (q.size() != 0) @(negedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (cs_w !== 1'b1 || we_w !== 1'b1 || re_w !== 1'b1 || a0_w !== 1'b1 ||
            dn_w !== 1'b0 || rdq_w !== 8'h00) begin
            n_fail++;
            $display("FAIL R1 reset: got cs%b we%b re%b a0%b dn%b rdq%02h expected 1111 dn0 rdq00",
                     cs_w, we_w, re_w, a0_w, dn_w, rdq_w);
        end
        @(posedge clk); #1;

        set_cfg(1, 10, 2, 6, 3, 8, 12, 14, 5, 1'b0, 4'b0000);
        run_access("R2 R3 write window", 1'b0, 1'b0, 0);
        run_access("R3 R11 read window", 1'b1, 1'b0, 0);
        run_access("R11 write holds capture", 1'b0, 1'b1, 0);
        set_cfg(4, 2, 5, 3, 7, 7, 2, 0, 2, 1'b0, 4'b0000);
        run_access("R4 R5 R6 clamped write", 1'b0, 1'b0, 0);
        run_access("R4 R5 R11 clamped read", 1'b1, 1'b1, 0);
        set_cfg(1, 10, 2, 6, 3, 8, 12, 14, 5, 1'b1, 4'b0000);
        run_access("R7 slow write", 1'b0, 1'b0, 0);
        run_access("R7 R11 slow read", 1'b1, 1'b0, 0);
        set_cfg(2, 9, 3, 7, 1, 5, 10, 11, 3, 1'b0, 4'b1111);
        run_access("R8 R9 active-high read cmd", 1'b1, 1'b1, 0);
        set_cfg(2, 9, 3, 7, 1, 5, 10, 11, 3, 1'b1, 4'b0101);
        run_access("R8 R9 mixed polarity write cmd", 1'b0, 1'b1, 0);
        set_cfg(0, 4, 1, 3, 0, 2, 20, 20, 1, 1'b0, 4'b0000);
        run_access("R10 start ignored while busy", 1'b0, 1'b0, 1);
        run_access("R2 zero on tick read", 1'b1, 1'b0, 0);
        set_cfg(3, 8, 4, 6, 2, 7, 15, 15, 4, 1'b0, 4'b0010);
        run_access("R12 inputs changed mid-access", 1'b1, 1'b1, 2);
        set_cfg(15, 63, 15, 63, 15, 63, 63, 63, 63, 1'b1, 4'b0000);
        run_access("R6 longest cycle write", 1'b0, 1'b0, 0);
        run_access("R6 R11 longest cycle read", 1'b1, 1'b0, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule